// File: doc/BRIEF.md
# Packet Ring Descriptor Manager

This block tracks the state of a fixed ring of outgoing data packets for a sender that retransmits until each packet is acknowledged. The packet payloads live elsewhere; this block holds one descriptor per ring slot. Each descriptor has a set number and three flags: valid (ready to send), sent (transmitted at least once) and confirmed (acknowledged). The producer fills slots in ring order at the head. A scanner visits one slot per clock and hands each valid, unconfirmed packet to a frame builder, one request at a time. Confirmed slots are retired at the tail, and the producer then reuses them for the same-index packet of the next set.

The ring has `SLOTS` entries, which must be a power of two (default 32). Set numbers are `SET_W` bits wide and wrap. A stop command halts the selection of new packets and keeps every descriptor. A start command resumes selection. Selection is halted after reset until the first start.

Top module: `pktring_top`

## Requirements
- R1: After reset, `txReq` is 0, `fillReady` is 1, `fillSlot` and `tailSlot` are 0, and `fillSet` is 0. Each slot's stored set starts at all ones, so the first fill of a slot gives set 0.
- R2: A fill is taken when `fillValid` and `fillReady` are both 1. It writes the slot shown on `fillSlot` and gives that slot the set shown on `fillSet`, which is the slot's previous set plus one, modulo 2^SET_W. It also sets valid and clears sent and confirmed. `fillSlot` then advances by one, modulo SLOTS.
- R3: When SLOTS slots are filled and not yet retired, `fillReady` is 0, and a `fillValid` pulse changes neither `fillSlot` nor `fillReady`.
- R4: While selection is running, the scanner visits slots in ascending order with wrap, one per clock. It issues a request for each slot that is valid and unconfirmed, giving `txSlot` and `txSet`.
- R5: Once `txReq` rises, it stays 1 with `txSlot`, `txSet` and `txRetry` unchanged until the clock edge at which `txDone` is 1. Only one request is outstanding at a time.
- R6: `txRetry` is 1 on a request exactly when that slot's sent flag was already set, meaning it had been sent before.
- R7: A packet that has not been acknowledged is requested again on the scanner's next pass.
- R8: An acknowledge (`ackValid`, `ackSlot`, `ackSet`) confirms a slot only if the slot is valid and its stored set equals `ackSet`. Stale acknowledges and acknowledges for retired slots have no effect. A confirmed packet is never requested again.
- R9: The tail moves forward over consecutive confirmed slots, at most one per clock. Each slot it passes becomes free for a fill. `tailSlot` shows the oldest unretired slot.
- R10: `stopCmd` stops the issuing of new requests from the same clock edge and lets an outstanding request finish. `startCmd` resumes issuing. If both arrive together, stop wins. Descriptors are kept across a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startCmd | input | 1 | Pulse: resume packet selection |
| stopCmd | input | 1 | Pulse: stop packet selection |
| fillValid | input | 1 | Producer offers the next packet |
| fillReady | output | 1 | Head slot is free to be filled |
| fillSlot | output | log2(SLOTS) | Slot the next fill will write |
| fillSet | output | SET_W | Set number the next fill will receive |
| ackValid | input | 1 | Acknowledge strobe |
| ackSlot | input | log2(SLOTS) | Slot being acknowledged |
| ackSet | input | SET_W | Set number carried by the acknowledge |
| txReq | output | 1 | Send request to the frame builder |
| txSlot | output | log2(SLOTS) | Slot to send |
| txSet | output | SET_W | Set number of the packet to send |
| txRetry | output | 1 | Request is a retransmission |
| txDone | input | 1 | Frame builder finished the current request |
| tailSlot | output | log2(SLOTS) | Oldest unretired slot |

## Verification
The hardest state to reach is a full ring in which a stale acknowledge must be rejected while every slot still holds an unretired packet. It also needs the second-generation set numbers on slots that wrapped past index 0. The stimulus reaches it in steps. It first sends, acknowledges and retires a few packets so the head sits partway round the ring. It then stops selection and fills all SLOTS slots, so the fill wraps into reused slots with set 1. Finally it sends a wrong-set acknowledge before the correct ones. A separate scenario stops selection while a request is outstanding, to show that the handshake still completes and that nothing new is issued afterwards.

// File: rtl/pktring_pkg.sv
package pktring_pkg;

  // Per-slot descriptor flags.
  typedef struct packed {
    logic valid;
    logic sent;
    logic confirmed;
  } slotFlags_t;

  // Strobes from the scan controller to the descriptor store.
  typedef struct packed {
    logic markSent;
  } scanStrobe_t;

endpackage

// File: rtl/pktring_desc_store.sv
module pktring_desc_store
  import pktring_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int SET_W = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillValid,
  output logic             fillReady,
  output logic [IDX_W-1:0] fillSlot,
  output logic [SET_W-1:0] fillSet,
  input  logic             ackValid,
  input  logic [IDX_W-1:0] ackSlot,
  input  logic [SET_W-1:0] ackSet,
  input  scanStrobe_t      strb,
  input  logic [IDX_W-1:0] markSlot,
  input  logic [SET_W-1:0] markSet,
  input  logic [IDX_W-1:0] rdSlot,
  output slotFlags_t       rdFlags,
  output logic [SET_W-1:0] rdSet,
  output logic [IDX_W-1:0] tailSlot
);

  slotFlags_t       flagsQ [SLOTS];
  logic [SET_W-1:0] setQ   [SLOTS];
  logic [IDX_W:0]   headQ, tailQ;
  logic [IDX_W-1:0] headIdx, tailIdx;
  logic             ringFull, ringEmpty, fillTake, retireEn;
  logic [SLOTS-1:0] fillHit, ackHit, markHit, retireHit;

  assign headIdx   = headQ[IDX_W-1:0];
  assign tailIdx   = tailQ[IDX_W-1:0];
  assign ringEmpty = (headQ == tailQ);
  assign ringFull  = (headQ[IDX_W] != tailQ[IDX_W]) && (headIdx == tailIdx);
  assign fillReady = !ringFull;
  assign fillTake  = fillValid && !ringFull;
  assign fillSlot  = headIdx;
  assign fillSet   = setQ[headIdx] + 1'b1;
  assign tailSlot  = tailIdx;
  assign retireEn  = !ringEmpty && flagsQ[tailIdx].valid && flagsQ[tailIdx].confirmed;

  assign rdFlags = flagsQ[rdSlot];
  assign rdSet   = setQ[rdSlot];

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : gSlot
      assign fillHit[g]   = fillTake && (headIdx == IDX_W'(g));
      assign retireHit[g] = retireEn && (tailIdx == IDX_W'(g));
      // Acknowledge counts only for a live slot of the matching set.
      assign ackHit[g]    = ackValid && (ackSlot == IDX_W'(g)) && flagsQ[g].valid
                            && !flagsQ[g].confirmed && (setQ[g] == ackSet);
      // Sent marking is guarded so a completed send never tags a refilled slot.
      assign markHit[g]   = strb.markSent && (markSlot == IDX_W'(g)) && flagsQ[g].valid
                            && (setQ[g] == markSet);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        flagsQ[i] <= '0;
        setQ[i]   <= '1;
      end
    end else begin
      if (fillTake) headQ <= headQ + 1'b1;
      if (retireEn) tailQ <= tailQ + 1'b1;
      for (int i = 0; i < SLOTS; i++) begin
        if (fillHit[i]) begin
          flagsQ[i].valid     <= 1'b1;
          flagsQ[i].sent      <= 1'b0;
          flagsQ[i].confirmed <= 1'b0;
          setQ[i]             <= setQ[i] + 1'b1;
        end else if (retireHit[i]) begin
          flagsQ[i] <= '0;
        end else begin
          if (ackHit[i])  flagsQ[i].confirmed <= 1'b1;
          if (markHit[i]) flagsQ[i].sent      <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pktring_scan_ctrl.sv
module pktring_scan_ctrl
  import pktring_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int SET_W = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startCmd,
  input  logic             stopCmd,
  input  slotFlags_t       rdFlags,
  input  logic [SET_W-1:0] rdSet,
  output logic [IDX_W-1:0] rdSlot,
  output scanStrobe_t      strb,
  output logic             txReq,
  output logic [IDX_W-1:0] txSlot,
  output logic [SET_W-1:0] txSet,
  output logic             txRetry,
  input  logic             txDone
);

  logic [IDX_W-1:0] scanQ;
  logic             pendQ, runQ;
  logic [IDX_W-1:0] txSlotQ;
  logic [SET_W-1:0] txSetQ;
  logic             txRetryQ;
  logic             eligible, canIssue;

  assign rdSlot        = scanQ;
  assign eligible      = rdFlags.valid && !rdFlags.confirmed;
  assign canIssue      = runQ && !stopCmd && !pendQ;
  assign strb.markSent = pendQ && txDone;

  assign txReq   = pendQ;
  assign txSlot  = txSlotQ;
  assign txSet   = txSetQ;
  assign txRetry = txRetryQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      pendQ    <= 1'b0;
      scanQ    <= '0;
      txSlotQ  <= '0;
      txSetQ   <= '0;
      txRetryQ <= 1'b0;
    end else begin
      if (stopCmd)       runQ <= 1'b0;
      else if (startCmd) runQ <= 1'b1;

      if (pendQ) begin
        if (txDone) begin
          pendQ <= 1'b0;
          scanQ <= scanQ + 1'b1;
        end
      end else if (canIssue) begin
        if (eligible) begin
          pendQ    <= 1'b1;
          txSlotQ  <= scanQ;
          txSetQ   <= rdSet;
          txRetryQ <= rdFlags.sent;
        end else begin
          scanQ <= scanQ + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pktring_top.sv
module pktring_top
  import pktring_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int SET_W = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startCmd,
  input  logic             stopCmd,
  input  logic             fillValid,
  output logic             fillReady,
  output logic [IDX_W-1:0] fillSlot,
  output logic [SET_W-1:0] fillSet,
  input  logic             ackValid,
  input  logic [IDX_W-1:0] ackSlot,
  input  logic [SET_W-1:0] ackSet,
  output logic             txReq,
  output logic [IDX_W-1:0] txSlot,
  output logic [SET_W-1:0] txSet,
  output logic             txRetry,
  input  logic             txDone,
  output logic [IDX_W-1:0] tailSlot
);

  slotFlags_t       rdFlags;
  logic [SET_W-1:0] rdSet;
  logic [IDX_W-1:0] rdSlot;
  scanStrobe_t      strb;

  pktring_desc_store #(.SLOTS(SLOTS), .SET_W(SET_W)) u_store (
    .clk(clk), .rstN(rstN),
    .fillValid(fillValid), .fillReady(fillReady), .fillSlot(fillSlot), .fillSet(fillSet),
    .ackValid(ackValid), .ackSlot(ackSlot), .ackSet(ackSet),
    .strb(strb), .markSlot(txSlot), .markSet(txSet),
    .rdSlot(rdSlot), .rdFlags(rdFlags), .rdSet(rdSet),
    .tailSlot(tailSlot)
  );

  pktring_scan_ctrl #(.SLOTS(SLOTS), .SET_W(SET_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startCmd(startCmd), .stopCmd(stopCmd),
    .rdFlags(rdFlags), .rdSet(rdSet), .rdSlot(rdSlot), .strb(strb),
    .txReq(txReq), .txSlot(txSlot), .txSet(txSet), .txRetry(txRetry),
    .txDone(txDone)
  );

endmodule

// File: rtl/pktring_checker.sv
module pktring_checker #(
  parameter int SLOTS = 32,
  parameter int SET_W = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             stopCmd,
  input logic             fillValid,
  input logic             fillReady,
  input logic [IDX_W-1:0] fillSlot,
  input logic             txReq,
  input logic [IDX_W-1:0] txSlot,
  input logic [SET_W-1:0] txSet,
  input logic             txRetry,
  input logic             txDone,
  input logic [IDX_W-1:0] tailSlot
);

  // R2: an accepted fill moves the head by exactly one slot
  assert_fill_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && fillReady) |=> (fillSlot == IDX_W'($past(fillSlot) + 1'b1)));

  // R5: a request holds steady until the done handshake
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !txDone) |=> (txReq && $stable(txSlot) && $stable(txSet) && $stable(txRetry)));

  // R9: the tail never jumps by more than one slot per clock
  assert_tail_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((tailSlot == $past(tailSlot)) || (tailSlot == IDX_W'($past(tailSlot) + 1'b1))));

  // R10: no new request appears after a stop
  assert_stop_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stopCmd && !txReq) |=> !txReq);

endmodule

bind pktring_top pktring_checker #(.SLOTS(SLOTS), .SET_W(SET_W)) u_checker (
  .clk(clk), .rstN(rstN), .stopCmd(stopCmd),
  .fillValid(fillValid), .fillReady(fillReady), .fillSlot(fillSlot),
  .txReq(txReq), .txSlot(txSlot), .txSet(txSet), .txRetry(txRetry),
  .txDone(txDone), .tailSlot(tailSlot)
);

// File: tb/tb_pktring_top.sv
module tb_pktring_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 32;
  localparam int SET_W = 8;
  localparam int IDX_W = $clog2(SLOTS);

  logic clk = 1'b0;
  logic rstN, startCmd, stopCmd, fillValid, ackValid, txDone;
  logic [IDX_W-1:0] ackSlot;
  logic [SET_W-1:0] ackSet;
  logic fillReady, txReq, txRetry;
  logic [IDX_W-1:0] fillSlot, txSlot, tailSlot;
  logic [SET_W-1:0] fillSet, txSet;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pktring_top #(.SLOTS(SLOTS), .SET_W(SET_W)) dut (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .stopCmd(stopCmd),
    .fillValid(fillValid), .fillReady(fillReady), .fillSlot(fillSlot), .fillSet(fillSet),
    .ackValid(ackValid), .ackSlot(ackSlot), .ackSet(ackSet),
    .txReq(txReq), .txSlot(txSlot), .txSet(txSet), .txRetry(txRetry),
    .txDone(txDone), .tailSlot(tailSlot)
  );

  task automatic checkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    startCmd = 1'b1; @(negedge clk); startCmd = 1'b0;
  endtask

  task automatic pulseStop();
    stopCmd = 1'b1; @(negedge clk); stopCmd = 1'b0;
  endtask

  task automatic fillOne(int expSlot, int expSet);
    checkEq("R2", "fillReady before fill", int'(fillReady), 1);
    checkEq("R2", "fillSlot", int'(fillSlot), expSlot);
    checkEq("R2", "fillSet", int'(fillSet), expSet);
    fillValid = 1'b1; @(negedge clk); fillValid = 1'b0;
  endtask

  task automatic ackOne(int slot, int set);
    ackValid = 1'b1; ackSlot = IDX_W'(slot); ackSet = SET_W'(set);
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  task automatic quietFor(string req, int cycles);
    int seen = 0;
    for (int k = 0; k < cycles; k++) begin
      if (txReq) seen++;
      @(negedge clk);
    end
    checkEq(req, "request cycles while none expected", seen, 0);
  endtask

  // Wait for a request, check it, complete it with a one-cycle done.
  task automatic expectSend(string req, int expSlot, int expSet, int expRetry);
    bit got = 1'b0;
    for (int k = 0; k < 200 && !got; k++) begin
      if (txReq) got = 1'b1;
      else @(negedge clk);
    end
    checkEq(req, "request seen", int'(got), 1);
    if (got) begin
      checkEq(req, "txSlot", int'(txSlot), expSlot);
      checkEq(req, "txSet", int'(txSet), expSet);
      checkEq("R6", "txRetry", int'(txRetry), expRetry);
      txDone = 1'b1; @(negedge clk); txDone = 1'b0;
    end
  endtask

  task automatic testReset();
    checkEq("R1", "txReq", int'(txReq), 0);
    checkEq("R1", "fillReady", int'(fillReady), 1);
    checkEq("R1", "fillSlot", int'(fillSlot), 0);
    checkEq("R1", "fillSet", int'(fillSet), 0);
    checkEq("R1", "tailSlot", int'(tailSlot), 0);
  endtask

  // R4 R7 R8 R9: cyclic sending, resend, ack matching, tail motion
  task automatic testSendAndResend();
    fillOne(0, 0); fillOne(1, 0); fillOne(2, 0);
    quietFor("R10", 20);                 // not started yet
    pulseStart();
    expectSend("R4", 0, 0, 0);
    expectSend("R4", 1, 0, 0);
    expectSend("R4", 2, 0, 0);
    expectSend("R7", 0, 0, 1);           // unacknowledged, sent again
    ackOne(0, 0);
    repeat (3) @(negedge clk);
    checkEq("R9", "tail after ack of slot 0", int'(tailSlot), 1);
    ackOne(1, 5);                        // wrong set: ignored
    expectSend("R8", 1, 0, 1);
    ackOne(1, 0);
    ackOne(2, 0);
    expectSend("R7", 2, 0, 1);           // already issued before ack
    quietFor("R8", 80);
    checkEq("R9", "tail after all acks", int'(tailSlot), 3);
  endtask

  // R2 R3 R8 R9: wrap into second set, full ring, stale ack
  task automatic testFullRing();
    pulseStop();
    quietFor("R10", 40);
    for (int k = 0; k < SLOTS; k++) begin
      int s = (3 + k) % SLOTS;
      fillOne(s, (s < 3) ? 1 : 0);
    end
    checkEq("R3", "fillReady when full", int'(fillReady), 0);
    fillValid = 1'b1; @(negedge clk); fillValid = 1'b0;
    @(negedge clk);
    checkEq("R3", "fillSlot after refused fill", int'(fillSlot), 3);
    checkEq("R3", "fillReady after refused fill", int'(fillReady), 0);
    ackOne(3, 1);                        // stale set on full ring
    repeat (4) @(negedge clk);
    checkEq("R8", "tail after stale ack", int'(tailSlot), 3);
    checkEq("R8", "fillReady after stale ack", int'(fillReady), 0);
    for (int k = 0; k < SLOTS; k++) begin
      int s = (3 + k) % SLOTS;
      ackOne(s, (s < 3) ? 1 : 0);
    end
    repeat (40) @(negedge clk);
    checkEq("R9", "tail after full drain", int'(tailSlot), 3);
    checkEq("R9", "fillReady after drain", int'(fillReady), 1);
    checkEq("R2", "next set for slot 3", int'(fillSet), 1);
  endtask

  // R5 R10 R6 R8: stop while a request is outstanding
  task automatic testStopPending();
    bit got = 1'b0;
    fillOne(3, 1);
    pulseStart();
    for (int k = 0; k < 200 && !got; k++) begin
      if (txReq) got = 1'b1;
      else @(negedge clk);
    end
    checkEq("R4", "request for slot 3", int'(got), 1);
    checkEq("R4", "txSlot", int'(txSlot), 3);
    checkEq("R6", "first send not retry", int'(txRetry), 0);
    pulseStop();
    checkEq("R5", "request held across stop", int'(txReq), 1);
    checkEq("R5", "txSlot held", int'(txSlot), 3);
    txDone = 1'b1; @(negedge clk); txDone = 1'b0;
    quietFor("R10", 50);
    pulseStart();
    expectSend("R7", 3, 1, 1);
    ackOne(3, 1);
    ackOne(3, 1);                        // duplicate
    quietFor("R8", 60);
    checkEq("R9", "tail after slot 3 ack", int'(tailSlot), 4);
    checkEq("R9", "fillReady", int'(fillReady), 1);
  endtask

  initial begin
    rstN = 1'b0; startCmd = 1'b0; stopCmd = 1'b0; fillValid = 1'b0;
    ackValid = 1'b0; ackSlot = '0; ackSet = '0; txDone = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSendAndResend();
    testFullRing();
    testStopPending();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule